// File: doc/BRIEF.md
# Scanline Timing and Display Status Generator

This block produces the raster timing for a fixed-resolution LCD controller. Every scanline is a draw phase followed by a horizontal-blank phase. Both phases are counted in dot periods, and each dot period is a fixed number of clocks. A line counter steps at the start of every draw phase and wraps back to zero after the last line of the frame. The block keeps a 16-bit status word. That word holds three flags owned by the hardware (vertical blank, horizontal blank, line match), three interrupt enables and a compare line.

The block emits one-cycle pulses for the following: the hblank request, the vblank request, the line-match request, frame start, frame end, and a draw-line request. The draw-line request carries the number of the line that the renderer should fill. Software reads the status word and the line counter through a small register port, and it can write the enables and the compare line. The line-match, vblank-set and vblank-clear events are all evaluated when a draw phase begins, against the new line number.

Top module: `scan_timing_gen`

## Requirements
- R1: A line lasts H_TOTAL dot periods of DOT_CLKS clocks each. After reset or after the start of a draw phase, the horizontal-blank flag rises after exactly (H_TOTAL-H_BLANK)*DOT_CLKS clocks. It falls again H_BLANK*DOT_CLKS clocks later.
- R2: The status bit 1 (in-hblank) is set on entry to horizontal blank and cleared on entry to draw. The output `irq_hblank` pulses for one cycle on the cycle the flag rises, and only if status bit 4 is set.
- R3: The line counter advances by one on each draw entry and goes from TOTAL_LINES-1 back to 0. Reading address 1 returns it, zero-extended to 16 bits.
- R4: On each draw entry, status bit 2 (line match) is set if the new line equals the compare field in status bits 15:7, and cleared otherwise. The output `irq_match` pulses with it when bit 5 is set.
- R5: Status bit 0 (in-vblank) is set on draw entry to line VIS_LINES and cleared on draw entry to line TOTAL_LINES-1. The output `irq_vblank` pulses at the set, only if bit 3 is set.
- R6: A write to address 0 leaves bits 2:0 untouched. It loads bits 5:3 and 15:7 from the written data. Bit 6 always reads 0.
- R7: The output `draw_req` pulses at horizontal-blank entry only when the current line is below VIS_LINES. `draw_line` then holds that line.
- R8: The output `frame_start` pulses on draw entry to line 0. The output `frame_end` pulses on draw entry to line VIS_LINES.
- R9: During and right after reset, the status word reads 0, the line counter reads 0, every pulse output is low, and the generator sits at the first clock of a draw phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 1 | 0 selects status, 1 selects line counter |
| reg_wr | input | 1 | Write strobe, status only |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| irq_hblank | output | 1 | Hblank interrupt request pulse |
| irq_vblank | output | 1 | Vblank interrupt request pulse |
| irq_match | output | 1 | Line-match interrupt request pulse |
| frame_start | output | 1 | Pulse when line 0 begins |
| frame_end | output | 1 | Pulse when vertical blank begins |
| draw_req | output | 1 | Draw-line request pulse |
| draw_line | output | LW | Line to render with draw_req |

## Verification
A wrong horizontal position shows as a changed distance between the edges of the hblank flag. This appears within one line. A wrong line counter or vblank flag breaks the relation between the line read-back and bit 0. It also moves the frame pulses and the count of draw requests per frame. All of this is visible within one frame of the small timing used by the bench. A compare or write-mask fault shows on the next draw entry, or on the very next status read.

// File: rtl/scan_pkg.sv
package scan_pkg;
   localparam int ST_VBLANK  = 0;
   localparam int ST_HBLANK  = 1;
   localparam int ST_MATCH   = 2;
   localparam int ST_VB_IE   = 3;
   localparam int ST_HB_IE   = 4;
   localparam int ST_MT_IE   = 5;
   localparam int ST_CMP_LSB = 7;
   localparam int CMP_W      = 9;
   localparam int REG_W      = 16;

   // phase-entry strobes from the horizontal timer
   typedef struct packed {
      logic blank_go;
      logic draw_go;
   } hevt_t;
endpackage

// File: rtl/scan_htimer.sv
module scan_htimer
   import scan_pkg::*;
#(
   parameter int DOT_CLKS = 6,
   parameter int H_TOTAL  = 355,
   parameter int H_BLANK  = 99
) (
   input  logic  clk,
   input  logic  rst_n,
   output hevt_t evt
);
   localparam int H_DRAW = H_TOTAL - H_BLANK;
   localparam int HW     = $clog2(H_TOTAL);
   localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
   localparam logic [HW-1:0] D_LAST  = HW'(H_DRAW - 1);

   logic          tick;
   logic [HW-1:0] hpos_q;

   generate
      if (DOT_CLKS == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(DOT_CLKS);
         localparam logic [PW-1:0] P_LAST = PW'(DOT_CLKS - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              pre_q <= '0;
            else if (pre_q == P_LAST) pre_q <= '0;
            else                     pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == P_LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                        hpos_q <= '0;
      else if (tick && hpos_q == H_LAST) hpos_q <= '0;
      else if (tick)                     hpos_q <= hpos_q + 1'b1;
   end

   assign evt.blank_go = tick && (hpos_q == D_LAST);
   assign evt.draw_go  = tick && (hpos_q == H_LAST);
endmodule

// File: rtl/scan_vcount.sv
module scan_vcount #(
   parameter int TOTAL_LINES = 263,
   parameter int LW          = $clog2(TOTAL_LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [LW-1:0] line_q,
   output logic [LW-1:0] line_nx
);
   localparam logic [LW-1:0] L_LAST = LW'(TOTAL_LINES - 1);

   assign line_nx = (line_q == L_LAST) ? '0 : line_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n)   line_q <= '0;
      else if (adv) line_q <= line_nx;
   end
endmodule

// File: rtl/scan_status.sv
module scan_status
   import scan_pkg::*;
#(
   parameter int VIS_LINES   = 192,
   parameter int TOTAL_LINES = 263,
   parameter int LW          = $clog2(TOTAL_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  hevt_t            evt,
   input  logic [LW-1:0]    line_q,
   input  logic [LW-1:0]    line_nx,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] status_q,
   output logic             irq_hb,
   output logic             irq_vb,
   output logic             irq_mt,
   output logic             frame_start,
   output logic             frame_end,
   output logic             draw_req,
   output logic [LW-1:0]    draw_line
);
   localparam logic [LW-1:0] L_VIS  = LW'(VIS_LINES);
   localparam logic [LW-1:0] L_LAST = LW'(TOTAL_LINES - 1);

   logic             vb_q, hb_q, mt_q;
   logic             vb_ie_q, hb_ie_q, mt_ie_q;
   logic [CMP_W-1:0] cmp_q;
   logic             hit_nx;

   assign hit_nx = (CMP_W'(line_nx) == cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vb_q <= 1'b0; hb_q <= 1'b0; mt_q <= 1'b0;
         vb_ie_q <= 1'b0; hb_ie_q <= 1'b0; mt_ie_q <= 1'b0;
         cmp_q <= '0;
         irq_hb <= 1'b0; irq_vb <= 1'b0; irq_mt <= 1'b0;
         frame_start <= 1'b0; frame_end <= 1'b0;
         draw_req <= 1'b0; draw_line <= '0;
      end else begin
         irq_hb <= 1'b0; irq_vb <= 1'b0; irq_mt <= 1'b0;
         frame_start <= 1'b0; frame_end <= 1'b0;
         draw_req <= 1'b0;
         if (wr_en) begin
            vb_ie_q <= wdata[ST_VB_IE];
            hb_ie_q <= wdata[ST_HB_IE];
            mt_ie_q <= wdata[ST_MT_IE];
            cmp_q   <= wdata[ST_CMP_LSB +: CMP_W];
         end
         if (evt.blank_go) begin
            hb_q      <= 1'b1;
            irq_hb    <= hb_ie_q;
            draw_req  <= (line_q < L_VIS);
            draw_line <= line_q;
         end
         if (evt.draw_go) begin
            hb_q        <= 1'b0;
            mt_q        <= hit_nx;
            irq_mt      <= hit_nx && mt_ie_q;
            frame_start <= (line_nx == '0);
            if (line_nx == L_VIS) begin
               vb_q      <= 1'b1;
               irq_vb    <= vb_ie_q;
               frame_end <= 1'b1;
            end
            if (line_nx == L_LAST) vb_q <= 1'b0;
         end
      end
   end

   assign status_q = {cmp_q, 1'b0, mt_ie_q, hb_ie_q, vb_ie_q, mt_q, hb_q, vb_q};
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
   import scan_pkg::*;
#(
   parameter int VIS_LINES   = 192,
   parameter int TOTAL_LINES = 263,
   parameter int DOT_CLKS    = 6,
   parameter int H_TOTAL     = 355,
   parameter int H_BLANK     = 99,
   parameter int LW          = $clog2(TOTAL_LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_addr,
   input  logic          reg_wr,
   input  logic [15:0]   reg_wdata,
   output logic [15:0]   reg_rdata,
   output logic          irq_hblank,
   output logic          irq_vblank,
   output logic          irq_match,
   output logic          frame_start,
   output logic          frame_end,
   output logic          draw_req,
   output logic [LW-1:0] draw_line
);
   generate
      if (H_BLANK < 1 || H_BLANK >= H_TOTAL) begin : g_bad_h
         $error("H_BLANK must be in 1..H_TOTAL-1");
      end
      if (DOT_CLKS < 1) begin : g_bad_dot
         $error("DOT_CLKS must be at least 1");
      end
      if (VIS_LINES < 1 || VIS_LINES >= TOTAL_LINES - 1) begin : g_bad_v
         $error("VIS_LINES must be in 1..TOTAL_LINES-2");
      end
      if (TOTAL_LINES > (1 << CMP_W) || LW > REG_W) begin : g_bad_t
         $error("TOTAL_LINES exceeds the compare field range");
      end
   endgenerate

   hevt_t          hevt;
   logic [LW-1:0]  line_q, line_nx;
   logic [15:0]    status_q;

   scan_htimer #(.DOT_CLKS(DOT_CLKS), .H_TOTAL(H_TOTAL), .H_BLANK(H_BLANK)) u_htimer (
      .clk(clk), .rst_n(rst_n), .evt(hevt));

   scan_vcount #(.TOTAL_LINES(TOTAL_LINES), .LW(LW)) u_vcount (
      .clk(clk), .rst_n(rst_n), .adv(hevt.draw_go),
      .line_q(line_q), .line_nx(line_nx));

   scan_status #(.VIS_LINES(VIS_LINES), .TOTAL_LINES(TOTAL_LINES), .LW(LW)) u_status (
      .clk(clk), .rst_n(rst_n), .evt(hevt),
      .line_q(line_q), .line_nx(line_nx),
      .wr_en(reg_wr && (reg_addr == 1'b0)), .wdata(reg_wdata),
      .status_q(status_q),
      .irq_hb(irq_hblank), .irq_vb(irq_vblank), .irq_mt(irq_match),
      .frame_start(frame_start), .frame_end(frame_end),
      .draw_req(draw_req), .draw_line(draw_line));

   assign reg_rdata = reg_addr ? 16'(line_q) : status_q;
endmodule

// File: rtl/scan_timing_chk.sv
module scan_timing_chk #(
   parameter int VIS_LINES   = 192,
   parameter int TOTAL_LINES = 263,
   parameter int LW          = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic [LW-1:0] line,
   input logic [15:0]   status,
   input logic          irq_hb,
   input logic          irq_vb,
   input logic          irq_mt,
   input logic          fs,
   input logic          fe,
   input logic          dreq,
   input logic [LW-1:0] dline
);
   localparam logic [LW-1:0] L_VIS  = LW'(VIS_LINES);
   localparam logic [LW-1:0] L_LAST = LW'(TOTAL_LINES - 1);

   p_hb_irq_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hb |-> status[1]);
   p_hb_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hb |=> !irq_hb);
   p_line_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      line <= L_LAST);
   p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (line != $past(line)) |->
         ((line == $past(line) + 1'b1) || (line == '0 && $past(line) == L_LAST)));
   p_match_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mt |-> (status[2] && status[5] && status[15:7] == 9'(line)));
   p_vb_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_vb |-> (status[0] && line == L_VIS));
   p_dreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dreq |-> (dline < L_VIS && status[1] && dline == line));
   p_frame_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fe |-> (status[0] && line == L_VIS));
   p_frame_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fs |-> (line == '0 && !status[0]));
endmodule

bind scan_timing_gen scan_timing_chk #(
   .VIS_LINES(VIS_LINES), .TOTAL_LINES(TOTAL_LINES), .LW(LW)) u_chk (
   .clk(clk), .rst_n(rst_n), .line(line_q), .status(status_q),
   .irq_hb(irq_hblank), .irq_vb(irq_vblank), .irq_mt(irq_match),
   .fs(frame_start), .fe(frame_end), .dreq(draw_req), .dline(draw_line));

// File: tb/scan_timing_gen_tb.sv
`timescale 1ns/1ps
module scan_timing_gen_tb;
   localparam int VIS   = 4;
   localparam int TOT   = 7;
   localparam int DOT   = 2;
   localparam int HT    = 6;
   localparam int HB    = 2;
   localparam int LW    = $clog2(TOT);
   localparam int LINE_CLKS  = HT * DOT;
   localparam int FRAME_CLKS = LINE_CLKS * TOT;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_addr = 1'b0;
   logic          reg_wr = 1'b0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          irq_hblank, irq_vblank, irq_match;
   logic          frame_start, frame_end, draw_req;
   logic [LW-1:0] draw_line;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   scan_timing_gen #(.VIS_LINES(VIS), .TOTAL_LINES(TOT), .DOT_CLKS(DOT),
                     .H_TOTAL(HT), .H_BLANK(HB)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_hblank(irq_hblank), .irq_vblank(irq_vblank), .irq_match(irq_match),
      .frame_start(frame_start), .frame_end(frame_end),
      .draw_req(draw_req), .draw_line(draw_line));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic a, output logic [15:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic wr_status(input logic [15:0] v);
      reg_addr = 1'b0; reg_wdata = v; reg_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_frame_start();
      for (int i = 0; i < 4 * FRAME_CLKS; i++) begin
         if (frame_start) return;
         step();
      end
      chk(1'b0, "R8 frame_start never seen", 0, 1);
   endtask

   task automatic t_reset();
      logic [15:0] s, l;
      rst_n = 1'b0;
      step(); step();
      rd(1'b0, s);
      chk(s == 16'h0, "R9 status in reset", s, 0);
      rd(1'b1, l);
      chk(l == 16'h0, "R9 line in reset", l, 0);
      chk({irq_hblank, irq_vblank, irq_match, frame_start, frame_end, draw_req} == 6'b0,
          "R9 pulses low in reset", 1, 0);
   endtask

   task automatic t_line_timing();
      logic [15:0] s, l;
      int n;
      rst_n = 1'b1;
      n = 0;
      do begin step(); n++; rd(1'b0, s); end while (!s[1] && n < 100);
      chk(n == (HT - HB) * DOT, "R1 draw length after reset", n, (HT - HB) * DOT);
      chk(irq_hblank == 1'b0, "R2 no hblank irq when disabled", irq_hblank, 0);
      rd(1'b1, l);
      chk(l == 0, "R3 line still 0 in first blank", l, 0);
      n = 0;
      do begin step(); n++; rd(1'b0, s); end while (s[1] && n < 100);
      chk(n == HB * DOT, "R1 blank length", n, HB * DOT);
      rd(1'b1, l);
      chk(l == 1, "R3 line advanced at draw entry", l, 1);
   endtask

   task automatic t_hblank_irq();
      logic [15:0] s;
      logic prev_hb, prev_irq;
      int pulses, bad;
      wr_status(16'h0010);
      rd(1'b0, s); prev_hb = s[1]; prev_irq = irq_hblank;
      pulses = 0; bad = 0;
      for (int i = 0; i < 2 * LINE_CLKS; i++) begin
         step(); rd(1'b0, s);
         if (irq_hblank) begin
            pulses++;
            if (!(s[1] && !prev_hb) || prev_irq) bad++;
         end
         prev_hb = s[1]; prev_irq = irq_hblank;
      end
      chk(pulses == 2, "R2 hblank irq count over two lines", pulses, 2);
      chk(bad == 0, "R2 hblank irq aligned with flag rise", bad, 0);
      wr_status(16'h0000);
      pulses = 0;
      for (int i = 0; i < 2 * LINE_CLKS; i++) begin
         step();
         if (irq_hblank) pulses++;
      end
      chk(pulses == 0, "R2 hblank irq masked", pulses, 0);
   endtask

   task automatic t_frame();
      logic [15:0] s, l;
      int dreqs, fends, fstarts, vbirq, bad_vb, bad_dl, maxl, seen0;
      wr_status(16'h0008);
      step();
      wait_frame_start();
      dreqs = 0; fends = 0; fstarts = 0; vbirq = 0; bad_vb = 0; bad_dl = 0; maxl = 0; seen0 = 0;
      for (int i = 0; i < FRAME_CLKS; i++) begin
         step();
         rd(1'b0, s); rd(1'b1, l);
         if (int'(l) > maxl) maxl = int'(l);
         if (s[0] != (l >= VIS && l <= TOT - 2)) bad_vb++;
         if (draw_req) begin
            dreqs++;
            if (draw_line != l[LW-1:0] || draw_line >= VIS) bad_dl++;
         end
         if (frame_end) fends++;
         if (frame_start) begin fstarts++; if (l == 0) seen0++; end
         if (irq_vblank) begin vbirq++; if (!frame_end) bad_vb++; end
      end
      chk(maxl == TOT - 1, "R3 highest line before wrap", maxl, TOT - 1);
      chk(seen0 == 1, "R3 wrap to line 0", seen0, 1);
      chk(bad_vb == 0, "R5 vblank flag span", bad_vb, 0);
      chk(vbirq == 1, "R5 vblank irq once per frame", vbirq, 1);
      chk(dreqs == VIS, "R7 draw requests per frame", dreqs, VIS);
      chk(bad_dl == 0, "R7 draw_line matches visible line", bad_dl, 0);
      chk(fends == 1, "R8 frame_end once per frame", fends, 1);
      chk(fstarts == 1, "R8 frame_start once per frame", fstarts, 1);
      wr_status(16'h0000);
      vbirq = 0;
      for (int i = 0; i < FRAME_CLKS; i++) begin
         step();
         if (irq_vblank) vbirq++;
      end
      chk(vbirq == 0, "R5 vblank irq masked", vbirq, 0);
   endtask

   task automatic t_match(input int cmpv, output int pulses, output int bad);
      logic [15:0] s, l;
      wr_status(16'((cmpv << 7) | 16'h0020));
      step();
      wait_frame_start();
      pulses = 0; bad = 0;
      for (int i = 0; i < FRAME_CLKS; i++) begin
         rd(1'b0, s); rd(1'b1, l);
         if (s[2] != (int'(l) == cmpv)) bad++;
         if (irq_match) begin pulses++; if (int'(l) != cmpv) bad++; end
         step();
      end
   endtask

   task automatic t_match_all();
      int p, b;
      t_match(2, p, b);
      chk(p == 1, "R4 match irq once per frame (line 2)", p, 1);
      chk(b == 0, "R4 match flag follows line 2", b, 0);
      t_match(TOT - 1, p, b);
      chk(p == 1, "R4 match irq on last line", p, 1);
      chk(b == 0, "R4 match flag on last line", b, 0);
      t_match(0, p, b);
      chk(p == 1, "R4 match irq on line 0", p, 1);
      chk(b == 0, "R4 match flag on line 0", b, 0);
   endtask

   task automatic t_write_protect();
      logic [15:0] s0, s1;
      wr_status(16'h0000);
      for (int i = 0; i < 2 * FRAME_CLKS; i++) begin
         if (frame_end) break;
         step();
      end
      rd(1'b0, s0);
      chk(s0[0] == 1'b1, "R6 vblank set before write", s0[0], 1);
      wr_status(16'hFFFF);
      rd(1'b0, s1);
      chk(s1[2:0] == s0[2:0], "R6 flags kept on write of ones", s1[2:0], s0[2:0]);
      chk(s1[5:3] == 3'b111, "R6 enables loaded", s1[5:3], 7);
      chk(s1[6] == 1'b0, "R6 reserved bit reads 0", s1[6], 0);
      chk(s1[15:7] == 9'h1FF, "R6 compare loaded", s1[15:7], 511);
      wr_status(16'h0000);
      rd(1'b0, s1);
      chk(s1[2:0] == s0[2:0], "R6 flags kept on write of zeros", s1[2:0], s0[2:0]);
      chk(s1[15:3] == 13'h0, "R6 upper fields cleared", s1[15:3], 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_line_timing();
      t_hblank_irq();
      t_frame();
      t_match_all();
      t_write_protect();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(FRAME_CLKS * 10 * 60);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule